// File: doc/BRIEF.md
# Status Register Transfer Unit

This block carries out the two instructions that move data between a processor's status registers and its general register file. A read-type instruction copies either the live status word or the saved status word of the current mode into a general register. A write-type instruction updates chosen bytes of one of the two status words. The new value comes either from a general register or from a small immediate that is rotated into place.

The core presents one instruction word per cycle with `valid_i`, along with the general register value it read, both status words and a privilege flag. One cycle later the unit drives back registered requests: a register-file write, a status write with per-byte enables, and strobes. The strobes report an undefined encoding, an access to a saved status word that the current mode does not own, and a change of the mode bits. The register file, the status registers themselves and the bank switching all live outside the block.

Top module: `status_xfer_unit`

## Requirements
- R1: With the 2-bit kind field (instruction bits 21:20) equal to 00, the unit writes the general register whose index is in bits 15:12. The value written is the current status word when bit 22 is 0 and the saved status word when bit 22 is 1.
- R2: With kind 10 and bit 25 set, the write operand is instruction bits 7:0, zero-extended to 32 bits and rotated right by twice the value in bits 11:8.
- R3: `rf_raddr_o` always equals instruction bits 3:0. With kind 10 and bit 25 clear, the write operand is `rm_data_i`.
- R4: For kind 10, `psr_be_o` equals mask bits 19:16, where bit n of the mask enables status bits 8n+7:8n. `psr_wdata_o` holds the operand in enabled bytes and the old value of the target word in the others. `psr_sel_o` equals bit 22.
- R5: A kind-10 instruction issued while `priv_i` is 0 produces no status write and no mode-change strobe.
- R6: When bit 22 is 1 and the current mode bits (`cpsr_i[4:0]`) are 10000 or 11111, the unit raises `bad_saved_o` and makes no register write and no status write, whatever the kind (00 or 10).
- R7: Kind values 01 and 11 raise `illegal_o` and produce no register or status write.
- R8: `mode_chg_o` is raised together with a status write to the current word whose merged bits 4:0 differ from `cpsr_i[4:0]`. It stays low otherwise.
- R9: All results appear on the outputs one clock after the cycle in which `valid_i` is high. After a cycle with `valid_i` low, every strobe and write enable is 0.
- R10: While `rst_n` is low, every registered output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction word present this cycle |
| instr_i | input | 32 | Instruction word |
| rm_data_i | input | 32 | Value of the general register addressed by `rf_raddr_o` |
| cpsr_i | input | 32 | Current status word |
| spsr_i | input | 32 | Saved status word of the current mode |
| priv_i | input | 1 | Core is in a privileged mode |
| rf_raddr_o | output | 4 | Source register index (combinational) |
| rf_we_o | output | 1 | General register write enable |
| rf_waddr_o | output | 4 | General register write index |
| rf_wdata_o | output | 32 | General register write data |
| psr_we_o | output | 1 | Status word write enable |
| psr_sel_o | output | 1 | 0 = current word, 1 = saved word |
| psr_be_o | output | 4 | Byte enables of the status write |
| psr_wdata_o | output | 32 | Merged status write data |
| mode_chg_o | output | 1 | Mode bits of the current word change |
| illegal_o | output | 1 | Undefined kind encoding |
| bad_saved_o | output | 1 | Saved word requested in a mode without one |

## Verification
Faulty decode state in this block shows at the ports exactly one cycle after the instruction. It can appear as the wrong write strobe or several strobes at once, a merged word in which a disabled byte has moved, or a rotation that lands the immediate in the wrong position. The scoreboard compares every output field of every cycle against a model built from the requirements, so a single bad result is caught on the cycle it appears. Immediate rotations are swept across all sixteen amounts, and masks cover the empty, partial and full cases. The mode pairs with and without a saved word are exercised for both read and write.

// File: rtl/srt_pkg.sv
package srt_pkg;
    localparam int unsigned P_DW    = 32;
    localparam int unsigned P_RIDX  = 4;
    localparam int unsigned P_IMM   = 8;
    localparam int unsigned P_ROT   = 4;
    localparam int unsigned P_LANES = P_DW / 8;
    localparam int unsigned P_MODE  = 5;

    typedef enum logic [1:0] {
        K_READ  = 2'b00,
        K_RSV1  = 2'b01,
        K_WRITE = 2'b10,
        K_RSV3  = 2'b11
    } kind_e;

    localparam logic [P_MODE-1:0] MODE_USER = 5'b10000;
    localparam logic [P_MODE-1:0] MODE_SYS  = 5'b11111;

    typedef struct packed {
        logic                rf_we;
        logic [P_RIDX-1:0]   rf_waddr;
        logic [P_DW-1:0]     rf_wdata;
        logic                psr_we;
        logic                psr_sel;
        logic [P_LANES-1:0]  psr_be;
        logic [P_DW-1:0]     psr_wdata;
        logic                mode_chg;
        logic                illegal;
        logic                bad_saved;
    } res_t;
endpackage

// File: rtl/srt_decode.sv
module srt_decode
    import srt_pkg::*;
#(
    parameter int unsigned DW    = P_DW,
    parameter int unsigned RIDX  = P_RIDX,
    parameter int unsigned IMM   = P_IMM,
    parameter int unsigned ROT   = P_ROT,
    parameter int unsigned LANES = P_LANES
) (
    input  logic [DW-1:0]    instr_i,
    output kind_e            kind_o,
    output logic             use_saved_o,
    output logic             use_imm_o,
    output logic [RIDX-1:0]  rd_o,
    output logic [RIDX-1:0]  rm_o,
    output logic [LANES-1:0] mask_o,
    output logic [IMM-1:0]   imm_o,
    output logic [ROT-1:0]   rot_o
);
    localparam int unsigned BIT_IMM   = 25;
    localparam int unsigned BIT_SAVED = 22;
    localparam int unsigned KIND_LO   = 20;
    localparam int unsigned MASK_LO   = 16;
    localparam int unsigned RD_LO     = 12;
    localparam int unsigned ROT_LO    = 8;

    logic unused_bits;

    always_comb begin
        kind_o      = kind_e'(instr_i[KIND_LO +: 2]);
        use_saved_o = instr_i[BIT_SAVED];
        use_imm_o   = instr_i[BIT_IMM];
        rd_o        = instr_i[RD_LO +: RIDX];
        rm_o        = instr_i[0 +: RIDX];
        mask_o      = instr_i[MASK_LO +: LANES];
        imm_o       = instr_i[0 +: IMM];
        rot_o       = instr_i[ROT_LO +: ROT];
    end

    assign unused_bits = ^{instr_i[DW-1:BIT_IMM+1], instr_i[BIT_IMM-1:BIT_SAVED+1]};
endmodule

// File: rtl/srt_operand.sv
module srt_operand
    import srt_pkg::*;
#(
    parameter int unsigned DW  = P_DW,
    parameter int unsigned IMM = P_IMM,
    parameter int unsigned ROT = P_ROT
) (
    input  logic           use_imm_i,
    input  logic [IMM-1:0] imm_i,
    input  logic [ROT-1:0] rot_i,
    input  logic [DW-1:0]  reg_i,
    output logic [DW-1:0]  operand_o
);
    localparam int unsigned AMT_W = ROT + 1;

    logic [AMT_W-1:0] amount;
    logic [DW-1:0]    imm_ext;
    logic [2*DW-1:0]  doubled;
    logic [2*DW-1:0]  shifted;

    always_comb begin
        amount    = {rot_i, 1'b0};
        imm_ext   = {{(DW-IMM){1'b0}}, imm_i};
        doubled   = {imm_ext, imm_ext};
        shifted   = doubled >> amount;
        operand_o = use_imm_i ? shifted[DW-1:0] : reg_i;
    end
endmodule

// File: rtl/srt_merge.sv
module srt_merge
    import srt_pkg::*;
#(
    parameter int unsigned DW    = P_DW,
    parameter int unsigned LANES = P_LANES
) (
    input  logic [DW-1:0]    old_i,
    input  logic [DW-1:0]    new_i,
    input  logic [LANES-1:0] en_i,
    output logic [DW-1:0]    merged_o
);
    localparam int unsigned LW = DW / LANES;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged_o[g*LW +: LW] = en_i[g] ? new_i[g*LW +: LW] : old_i[g*LW +: LW];
    end
endmodule

// File: rtl/status_xfer_unit.sv
module status_xfer_unit
    import srt_pkg::*;
#(
    parameter int unsigned DW    = P_DW,
    parameter int unsigned RIDX  = P_RIDX,
    parameter int unsigned LANES = P_LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [DW-1:0]    instr_i,
    input  logic [DW-1:0]    rm_data_i,
    input  logic [DW-1:0]    cpsr_i,
    input  logic [DW-1:0]    spsr_i,
    input  logic             priv_i,
    output logic [RIDX-1:0]  rf_raddr_o,
    output logic             rf_we_o,
    output logic [RIDX-1:0]  rf_waddr_o,
    output logic [DW-1:0]    rf_wdata_o,
    output logic             psr_we_o,
    output logic             psr_sel_o,
    output logic [LANES-1:0] psr_be_o,
    output logic [DW-1:0]    psr_wdata_o,
    output logic             mode_chg_o,
    output logic             illegal_o,
    output logic             bad_saved_o
);
    kind_e               kind;
    logic                use_saved;
    logic                use_imm;
    logic [RIDX-1:0]     rd_idx;
    logic [RIDX-1:0]     rm_idx;
    logic [LANES-1:0]    mask;
    logic [P_IMM-1:0]    imm8;
    logic [P_ROT-1:0]    rot;
    logic [DW-1:0]       operand;
    logic [DW-1:0]       target;
    logic [DW-1:0]       merged;
    logic                no_saved;
    res_t                res_d;
    res_t                res_q;

    srt_decode #(.DW(DW), .RIDX(RIDX), .IMM(P_IMM), .ROT(P_ROT), .LANES(LANES)) u_decode (
        .instr_i     (instr_i),
        .kind_o      (kind),
        .use_saved_o (use_saved),
        .use_imm_o   (use_imm),
        .rd_o        (rd_idx),
        .rm_o        (rm_idx),
        .mask_o      (mask),
        .imm_o       (imm8),
        .rot_o       (rot)
    );

    srt_operand #(.DW(DW), .IMM(P_IMM), .ROT(P_ROT)) u_operand (
        .use_imm_i (use_imm),
        .imm_i     (imm8),
        .rot_i     (rot),
        .reg_i     (rm_data_i),
        .operand_o (operand)
    );

    assign target = use_saved ? spsr_i : cpsr_i;

    srt_merge #(.DW(DW), .LANES(LANES)) u_merge (
        .old_i    (target),
        .new_i    (operand),
        .en_i     (mask),
        .merged_o (merged)
    );

    assign rf_raddr_o = rm_idx;

    always_comb begin
        no_saved = (cpsr_i[P_MODE-1:0] == MODE_USER) || (cpsr_i[P_MODE-1:0] == MODE_SYS);
        res_d    = '0;
        if (valid_i) begin
            unique case (kind)
                K_READ: begin
                    if (use_saved && no_saved) begin
                        res_d.bad_saved = 1'b1;
                    end else begin
                        res_d.rf_we    = 1'b1;
                        res_d.rf_waddr = rd_idx;
                        res_d.rf_wdata = target;
                    end
                end
                K_WRITE: begin
                    if (use_saved && no_saved) begin
                        res_d.bad_saved = 1'b1;
                    end else if (priv_i) begin
                        res_d.psr_we    = 1'b1;
                        res_d.psr_sel   = use_saved;
                        res_d.psr_be    = mask;
                        res_d.psr_wdata = merged;
                        res_d.mode_chg  = !use_saved &&
                                          (merged[P_MODE-1:0] != cpsr_i[P_MODE-1:0]);
                    end
                end
                default: res_d.illegal = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign rf_we_o     = res_q.rf_we;
    assign rf_waddr_o  = res_q.rf_waddr;
    assign rf_wdata_o  = res_q.rf_wdata;
    assign psr_we_o    = res_q.psr_we;
    assign psr_sel_o   = res_q.psr_sel;
    assign psr_be_o    = res_q.psr_be;
    assign psr_wdata_o = res_q.psr_wdata;
    assign mode_chg_o  = res_q.mode_chg;
    assign illegal_o   = res_q.illegal;
    assign bad_saved_o = res_q.bad_saved;
endmodule

// File: rtl/srt_chk.sv
module srt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        valid_i,
    input logic [31:0] instr_i,
    input logic [31:0] cpsr_i,
    input logic        priv_i,
    input logic [3:0]  rf_raddr_o,
    input logic        rf_we_o,
    input logic        psr_we_o,
    input logic        psr_sel_o,
    input logic        mode_chg_o,
    input logic        illegal_o,
    input logic        bad_saved_o
);
    // R5
    unpriv_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !priv_i && instr_i[21:20] == 2'b10) |=> (!psr_we_o && !mode_chg_o));

    // R7
    illegal_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && instr_i[20]) |=> (illegal_o && !rf_we_o && !psr_we_o));

    // R6
    no_saved_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && instr_i[22] && !instr_i[20] &&
         (cpsr_i[4:0] == 5'b10000 || cpsr_i[4:0] == 5'b11111))
        |=> (bad_saved_o && !rf_we_o && !psr_we_o));

    // R8
    mode_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg_o |-> (psr_we_o && !psr_sel_o));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !(rf_we_o || psr_we_o || illegal_o || bad_saved_o || mode_chg_o));

    // R9
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_we_o, psr_we_o, illegal_o, bad_saved_o}));

    // R3
    always_comb begin
        raddr_field_chk: assert (rf_raddr_o == instr_i[3:0]);
    end
endmodule

bind status_xfer_unit srt_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (valid_i),
    .instr_i     (instr_i),
    .cpsr_i      (cpsr_i),
    .priv_i      (priv_i),
    .rf_raddr_o  (rf_raddr_o),
    .rf_we_o     (rf_we_o),
    .psr_we_o    (psr_we_o),
    .psr_sel_o   (psr_sel_o),
    .mode_chg_o  (mode_chg_o),
    .illegal_o   (illegal_o),
    .bad_saved_o (bad_saved_o)
);

// File: tb/status_xfer_unit_tb.sv
module status_xfer_unit_tb;
    typedef struct {
        logic        rf_we;
        logic [3:0]  rf_waddr;
        logic [31:0] rf_wdata;
        logic        psr_we;
        logic        psr_sel;
        logic [3:0]  psr_be;
        logic [31:0] psr_wdata;
        logic        mode_chg;
        logic        illegal;
        logic        bad_saved;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] rm_data_i = '0;
    logic [31:0] cpsr_i = '0;
    logic [31:0] spsr_i = '0;
    logic        priv_i = 1'b0;
    logic [3:0]  rf_raddr_o;
    logic        rf_we_o;
    logic [3:0]  rf_waddr_o;
    logic [31:0] rf_wdata_o;
    logic        psr_we_o;
    logic        psr_sel_o;
    logic [3:0]  psr_be_o;
    logic [31:0] psr_wdata_o;
    logic        mode_chg_o;
    logic        illegal_o;
    logic        bad_saved_o;

    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 0;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    status_xfer_unit u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
        .rm_data_i(rm_data_i), .cpsr_i(cpsr_i), .spsr_i(spsr_i), .priv_i(priv_i),
        .rf_raddr_o(rf_raddr_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
        .rf_wdata_o(rf_wdata_o), .psr_we_o(psr_we_o), .psr_sel_o(psr_sel_o),
        .psr_be_o(psr_be_o), .psr_wdata_o(psr_wdata_o), .mode_chg_o(mode_chg_o),
        .illegal_o(illegal_o), .bad_saved_o(bad_saved_o)
    );

    function automatic logic [31:0] mk(bit imm, bit saved, logic [1:0] kind,
                                       logic [3:0] mask, logic [3:0] rd,
                                       logic [3:0] rot, logic [7:0] low);
        return {4'hE, 2'b00, imm, 2'b10, saved, kind, mask, rd, rot, low};
    endfunction

    function automatic exp_t model(logic v, logic [31:0] ins, logic [31:0] rm,
                                   logic [31:0] cp, logic [31:0] sp, logic pv, string tag);
        exp_t e;
        logic [31:0] opnd, tgt, mrg;
        logic        lacks;
        e = '{rf_we:0, rf_waddr:0, rf_wdata:0, psr_we:0, psr_sel:0, psr_be:0,
              psr_wdata:0, mode_chg:0, illegal:0, bad_saved:0, tag:tag};
        lacks = (cp[4:0] == 5'b10000) || (cp[4:0] == 5'b11111);
        tgt   = ins[22] ? sp : cp;
        if (ins[25]) begin
            opnd = {24'h0, ins[7:0]};
            for (int k = 0; k < 2 * ins[11:8]; k++) opnd = {opnd[0], opnd[31:1]};
        end else opnd = rm;
        for (int b = 0; b < 4; b++) mrg[b*8 +: 8] = ins[16+b] ? opnd[b*8 +: 8] : tgt[b*8 +: 8];
        if (v) begin
            if (ins[21:20] == 2'b00) begin
                if (ins[22] && lacks) e.bad_saved = 1;
                else begin e.rf_we = 1; e.rf_waddr = ins[15:12]; e.rf_wdata = tgt; end
            end else if (ins[21:20] == 2'b10) begin
                if (ins[22] && lacks) e.bad_saved = 1;
                else if (pv) begin
                    e.psr_we = 1; e.psr_sel = ins[22]; e.psr_be = ins[19:16];
                    e.psr_wdata = mrg;
                    e.mode_chg = !ins[22] && (mrg[4:0] != cp[4:0]);
                end
            end else e.illegal = 1;
        end
        return e;
    endfunction

    task automatic send(logic v, logic [31:0] ins, logic [31:0] rm, logic [31:0] cp,
                        logic [31:0] sp, logic pv, string tag);
        @(negedge clk);
        valid_i = v; instr_i = ins; rm_data_i = rm; cpsr_i = cp; spsr_i = sp; priv_i = pv;
        exp_q.push_back(model(v, ins, rm, cp, sp, pv, tag));
        #1;
        n_run++;
        if (rf_raddr_o !== ins[3:0]) begin
            n_fail++;
            $display("FAIL R3 raddr act=%h exp=%h", rf_raddr_o, ins[3:0]);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_run++;
            if (rf_we_o !== e.rf_we || rf_waddr_o !== e.rf_waddr || rf_wdata_o !== e.rf_wdata ||
                psr_we_o !== e.psr_we || psr_sel_o !== e.psr_sel || psr_be_o !== e.psr_be ||
                psr_wdata_o !== e.psr_wdata || mode_chg_o !== e.mode_chg ||
                illegal_o !== e.illegal || bad_saved_o !== e.bad_saved) begin
                n_fail++;
                $display("FAIL %s act=%b/%h/%h %b%b/%h/%h m%b i%b b%b exp=%b/%h/%h %b%b/%h/%h m%b i%b b%b",
                    e.tag, rf_we_o, rf_waddr_o, rf_wdata_o, psr_we_o, psr_sel_o, psr_be_o,
                    psr_wdata_o, mode_chg_o, illegal_o, bad_saved_o,
                    e.rf_we, e.rf_waddr, e.rf_wdata, e.psr_we, e.psr_sel, e.psr_be,
                    e.psr_wdata, e.mode_chg, e.illegal, e.bad_saved);
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog act=running exp=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    localparam logic [31:0] SVC = 32'h6000_0013;
    localparam logic [31:0] USR = 32'h2000_0010;
    localparam logic [31:0] SYS = 32'h8000_001F;
    localparam logic [31:0] SAV = 32'hA5C3_0011;

    initial begin
        repeat (3) @(negedge clk);
        n_run++;
        if ({rf_we_o, psr_we_o, mode_chg_o, illegal_o, bad_saved_o, rf_wdata_o, psr_wdata_o} !== '0) begin
            n_fail++;
            $display("FAIL R10 reset outputs act=nonzero exp=0");
        end
        rst_n = 1'b1;
        // R1 read current and saved words
        send(1, mk(0, 0, 2'b00, 4'h0, 4'd5, 4'h0, 8'h00), 0, SVC, SAV, 1, "R1 read current");
        send(1, mk(0, 1, 2'b00, 4'h0, 4'd14, 4'h0, 8'h07), 0, SVC, SAV, 1, "R1 read saved");
        // R6 saved word absent in user and system modes
        send(1, mk(0, 1, 2'b00, 4'h0, 4'd2, 4'h0, 8'h00), 0, USR, SAV, 0, "R6 read saved user");
        send(1, mk(0, 1, 2'b10, 4'hF, 4'd0, 4'h0, 8'h00), 32'h1234_5678, SYS, SAV, 1, "R6 write saved system");
        // R2 immediate rotations, all sixteen amounts
        for (int r = 0; r < 16; r++)
            send(1, mk(1, 0, 2'b10, 4'hF, 4'd0, 4'(r), 8'hB1), 0, SVC, SAV, 1, "R2 rotate sweep");
        send(1, mk(1, 0, 2'b10, 4'h8, 4'd0, 4'h4, 8'hF0), 0, SVC, SAV, 1, "R2 flag byte imm");
        // R3 register operand, R4 masks
        send(1, mk(0, 0, 2'b10, 4'h0, 4'd0, 4'h0, 8'h03), 32'hFFFF_FFFF, SVC, SAV, 1, "R4 empty mask");
        send(1, mk(0, 0, 2'b10, 4'h6, 4'd0, 4'h0, 8'h09), 32'hDEAD_BEEF, SVC, SAV, 1, "R3 reg operand");
        send(1, mk(0, 1, 2'b10, 4'hF, 4'd0, 4'h0, 8'h01), 32'h0BAD_F00D, SVC, SAV, 1, "R4 saved full mask");
        // R8 mode change strobe
        send(1, mk(0, 0, 2'b10, 4'h1, 4'd0, 4'h0, 8'h04), 32'h0000_0012, SVC, SAV, 1, "R8 mode change");
        send(1, mk(0, 0, 2'b10, 4'h1, 4'd0, 4'h0, 8'h04), 32'hFFFF_FF13, SVC, SAV, 1, "R8 same mode");
        send(1, mk(0, 0, 2'b10, 4'h2, 4'd0, 4'h0, 8'h04), 32'h0000_0000, SVC, SAV, 1, "R8 mode byte off");
        // R5 unprivileged
        send(1, mk(0, 0, 2'b10, 4'hF, 4'd0, 4'h0, 8'h04), 32'h0000_001F, USR, SAV, 0, "R5 unprivileged");
        send(1, mk(1, 0, 2'b10, 4'h9, 4'd0, 4'h1, 8'hFF), 0, SVC, SAV, 0, "R5 unpriv imm");
        // R7 undefined kinds
        send(1, mk(0, 0, 2'b01, 4'hF, 4'd3, 4'h0, 8'h00), 1, SVC, SAV, 1, "R7 kind 01");
        send(1, mk(0, 1, 2'b11, 4'hF, 4'd3, 4'h0, 8'h00), 1, USR, SAV, 1, "R7 kind 11");
        // R9 idle cycles with noisy inputs
        send(0, mk(0, 0, 2'b10, 4'hF, 4'd3, 4'h0, 8'h00), 32'h13, SVC, SAV, 1, "R9 idle");
        send(0, mk(0, 0, 2'b00, 4'hF, 4'd3, 4'h0, 8'h00), 32'h13, SVC, SAV, 1, "R9 idle");
        // mixed random traffic
        for (int i = 0; i < 200; i++) begin
            logic [31:0] cp;
            logic [4:0]  md;
            case ($urandom_range(0, 3))
                0: md = 5'b10000; 1: md = 5'b11111; 2: md = 5'b10011; default: md = 5'b10010;
            endcase
            cp = {$urandom(), md};
            send(($urandom_range(0, 7) != 0), $urandom(), $urandom(), cp, $urandom(),
                 1'($urandom_range(0, 1)), "R9 random");
        end
        send(0, 0, 0, 0, 0, 0, "R9 drain");
        send(0, 0, 0, 0, 0, 0, "R9 drain");
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule